// File: doc/BRIEF.md
# External Asynchronous Bus Controller

This block is a bus master for slow external memories and peripherals on a non-multiplexed bus. An internal host raises a request together with an address, a direction, an optional burst flag and three timing counts. The controller then runs one timed access on the external pins: address, a narrow data path, an active-low chip select, an active-low output enable, an active-low write enable and an active-low one-clock transfer-start strobe. When the access is done it pulses an acknowledge back to the host.

Every access follows the same phases. First an address clock with the start strobe. Then optional address-setup clocks. Then a strobe clock where chip select and the read or write enable assert. Then optional wait-state clocks and a data clock. Then a completion clock in which all strobes drop and the host is acknowledged. Optional address-hold clocks follow, with the address still driven. A burst read gathers several port-width beats into one host word.

Top module: `xbus_ctrl`

## Requirements
- R1: With zero setup, wait and hold counts, the acknowledge arrives in the 4th clock, counting the start-strobe clock as clock 1.
- R2: Each wait state delays the acknowledge by one clock. A single access acknowledges in clock 4 + setup + wait.
- R3: During the start-strobe clock the latched host address is on the bus and chip select is high. Chip select first goes low exactly 1 + setup clocks after the start-strobe clock.
- R4: After the acknowledge, for the effective hold count of clocks, the bus keeps the last address and every strobe stays high.
- R5: A read drives output enable low and never write enable. A write drives write enable low and never output enable, with the data-drive enable high and the low port-width byte of the host write data on the bus. Both follow the same phase timing.
- R6: A burst read transfers HOST_W/PORT_W beats at consecutive port addresses (base + beat index, modulo the address width). Setup and wait apply to the first beat only, and each later beat takes one clock. The acknowledge comes in clock 3 + setup + wait + beats. The effective hold count is max(hold, 1), so a default 32-bit burst on an 8-bit port occupies 8 clocks. Beat k lands in host data bits [8k+7:8k], first beat least significant.
- R7: The burst flag has no effect on a write; it runs as a single write.
- R8: The direction, burst flag, address, write data and timing counts are latched when a request is accepted. Changing them during the access has no effect on its timing, address or data.
- R9: The acknowledge is high for exactly one clock. For a read the host data is valid in that clock, and a single read returns the port byte zero-extended.
- R10: A request held high is not accepted until the previous access, hold clocks included, has finished. The next start strobe comes exactly effective-hold + 2 clocks after the previous acknowledge.
- R11: Synchronous reset drives all strobes high and the acknowledge low.
- R12: The start strobe is low for exactly one clock per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Request, held high until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_burst | input | 1 | Burst read of one full host word |
| host_addr | input | ADDR_W | Start address in port-width units |
| host_wdata | input | PORT_W | Write data |
| cfg_setup | input | SETUP_W | Address-setup clocks (0..3) |
| cfg_wait | input | WAIT_W | Wait-state clocks (0..63) |
| cfg_hold | input | HOLD_W | Address-hold clocks (0..3) |
| host_ack | output | 1 | One-clock completion pulse |
| host_rdata | output | HOST_W | Assembled read data |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | PORT_W | External write data |
| bus_dout_en | output | 1 | Data-drive enable for the external data path |
| bus_din | input | PORT_W | External read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_ts_n | output | 1 | Transfer-start strobe, active low |

## Verification
The acknowledge of one access can fall in the same clock as a new request with different fields, and the hold clocks that follow also see that pending request. The bench chains every transfer. It presents the next request's fields in the clock the acknowledge is seen and keeps the request high through the hold clocks. It then judges three things: the next start strobe lands exactly effective-hold + 2 clocks later, the bus stays quiet with a stable address during hold, and the new access uses its own fields and not the ones of the access still finishing.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ADDR   = 3'd1,
      PH_SETUP  = 3'd2,
      PH_STROBE = 3'd3,
      PH_WAIT   = 3'd4,
      PH_DATA   = 3'd5,
      PH_DONE   = 3'd6,
      PH_HOLD   = 3'd7
   } phase_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq #(
   parameter int SETUP_W = 2,
   parameter int WAIT_W  = 6,
   parameter int HOLD_W  = 2,
   parameter int BEATS   = 4,
   parameter int BEAT_W  = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                req_i,
   input  logic                we_i,
   input  logic                burst_i,
   input  logic [SETUP_W-1:0]  setup_i,
   input  logic [WAIT_W-1:0]   wait_i,
   input  logic [HOLD_W-1:0]   hold_i,
   output logic                accept_o,
   output xbus_pkg::phase_e    phase_o,
   output logic [BEAT_W-1:0]   beat_o,
   output logic                we_o
);
   import xbus_pkg::*;

   localparam int CNT_W = (WAIT_W > SETUP_W) ? ((WAIT_W > HOLD_W) ? WAIT_W : HOLD_W)
                                             : ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W);

   phase_e             phase_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [BEAT_W-1:0]  beat_q;
   logic [SETUP_W-1:0] setup_q;
   logic [WAIT_W-1:0]  wait_q;
   logic [HOLD_W-1:0]  hold_q;
   logic               we_q;
   logic               burst_q;
   logic [HOLD_W-1:0]  hold_eff;

   // a burst always leaves at least one recovery clock
   assign hold_eff = (burst_q && hold_q == '0) ? HOLD_W'(1) : hold_q;
   assign accept_o = (phase_q == PH_IDLE) && req_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
         beat_q  <= '0;
         setup_q <= '0;
         wait_q  <= '0;
         hold_q  <= '0;
         we_q    <= 1'b0;
         burst_q <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: if (req_i) begin
               setup_q <= setup_i;
               wait_q  <= wait_i;
               hold_q  <= hold_i;
               we_q    <= we_i;
               burst_q <= burst_i & ~we_i;
               beat_q  <= '0;
               phase_q <= PH_ADDR;
            end
            PH_ADDR: if (setup_q != '0) begin
               cnt_q   <= CNT_W'(setup_q) - CNT_W'(1);
               phase_q <= PH_SETUP;
            end else begin
               phase_q <= PH_STROBE;
            end
            PH_SETUP: if (cnt_q == '0) phase_q <= PH_STROBE;
                      else cnt_q <= cnt_q - CNT_W'(1);
            PH_STROBE: if (wait_q != '0) begin
               cnt_q   <= CNT_W'(wait_q) - CNT_W'(1);
               phase_q <= PH_WAIT;
            end else begin
               phase_q <= PH_DATA;
            end
            PH_WAIT: if (cnt_q == '0) phase_q <= PH_DATA;
                     else cnt_q <= cnt_q - CNT_W'(1);
            PH_DATA: if (burst_q && beat_q != BEAT_W'(BEATS - 1)) beat_q <= beat_q + BEAT_W'(1);
                     else phase_q <= PH_DONE;
            PH_DONE: if (hold_eff != '0) begin
               cnt_q   <= CNT_W'(hold_eff) - CNT_W'(1);
               phase_q <= PH_HOLD;
            end else begin
               phase_q <= PH_IDLE;
            end
            PH_HOLD: if (cnt_q == '0) phase_q <= PH_IDLE;
                     else cnt_q <= cnt_q - CNT_W'(1);
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign beat_o  = beat_q;
   assign we_o    = we_q;
endmodule

// File: rtl/xbus_rd_pack.sv
module xbus_rd_pack #(
   parameter int PORT_W = 8,
   parameter int BEATS  = 4,
   parameter int BEAT_W = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clear_i,
   input  logic                    cap_i,
   input  logic [BEAT_W-1:0]       beat_i,
   input  logic [PORT_W-1:0]       din_i,
   output logic [PORT_W*BEATS-1:0] word_o
);
   for (genvar g = 0; g < BEATS; g++) begin : g_lane
      logic [PORT_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (rst || clear_i)                          lane_q <= '0;
         else if (cap_i && beat_i == BEAT_W'(g))      lane_q <= din_i;
      end
      assign word_o[g*PORT_W +: PORT_W] = lane_q;
   end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl #(
   parameter int ADDR_W  = 16,
   parameter int PORT_W  = 8,
   parameter int HOST_W  = 32,
   parameter int SETUP_W = 2,
   parameter int WAIT_W  = 6,
   parameter int HOLD_W  = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               host_req,
   input  logic               host_we,
   input  logic               host_burst,
   input  logic [ADDR_W-1:0]  host_addr,
   input  logic [PORT_W-1:0]  host_wdata,
   input  logic [SETUP_W-1:0] cfg_setup,
   input  logic [WAIT_W-1:0]  cfg_wait,
   input  logic [HOLD_W-1:0]  cfg_hold,
   output logic               host_ack,
   output logic [HOST_W-1:0]  host_rdata,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [PORT_W-1:0]  bus_dout,
   output logic               bus_dout_en,
   input  logic [PORT_W-1:0]  bus_din,
   output logic               bus_cs_n,
   output logic               bus_oe_n,
   output logic               bus_we_n,
   output logic               bus_ts_n
);
   import xbus_pkg::*;

   localparam int BEATS  = HOST_W / PORT_W;
   localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (HOST_W % PORT_W != 0) begin : g_bad_ratio
      $error("HOST_W must be a multiple of PORT_W");
   end
   if (BEATS < 2) begin : g_bad_beats
      $error("HOST_W must hold at least two port beats");
   end
   if (ADDR_W < BEAT_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the burst length");
   end

   phase_e              phase;
   logic                accept;
   logic [BEAT_W-1:0]   beat;
   logic                we;
   logic [ADDR_W-1:0]   addr_q;
   logic [PORT_W-1:0]   wdata_q;
   logic                strobe_ph;

   xbus_seq #(
      .SETUP_W(SETUP_W), .WAIT_W(WAIT_W), .HOLD_W(HOLD_W),
      .BEATS(BEATS), .BEAT_W(BEAT_W)
   ) u_seq (
      .clk(clk), .rst(rst), .req_i(host_req), .we_i(host_we), .burst_i(host_burst),
      .setup_i(cfg_setup), .wait_i(cfg_wait), .hold_i(cfg_hold),
      .accept_o(accept), .phase_o(phase), .beat_o(beat), .we_o(we)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= host_addr;
         wdata_q <= host_wdata;
      end
   end

   xbus_rd_pack #(.PORT_W(PORT_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_pack (
      .clk(clk), .rst(rst), .clear_i(accept),
      .cap_i(phase == PH_DATA && !we), .beat_i(beat), .din_i(bus_din),
      .word_o(host_rdata)
   );

   assign strobe_ph   = (phase == PH_STROBE) || (phase == PH_WAIT) || (phase == PH_DATA);
   assign bus_addr    = addr_q + ADDR_W'(beat);
   assign bus_dout    = wdata_q;
   assign bus_dout_en = we && (strobe_ph || phase == PH_DONE);
   assign bus_ts_n    = !(phase == PH_ADDR);
   assign bus_cs_n    = !strobe_ph;
   assign bus_oe_n    = !(strobe_ph && !we);
   assign bus_we_n    = !(strobe_ph && we);
   assign host_ack    = (phase == PH_DONE);
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              host_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_cs_n,
   input logic              bus_oe_n,
   input logic              bus_we_n,
   input logic              bus_ts_n
);
   assert_ts_one_clock_R12: assert property (@(posedge clk) disable iff (rst)
      !bus_ts_n |=> bus_ts_n);

   assert_ack_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> !host_ack);

   assert_oe_we_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
      !(!bus_oe_n && !bus_we_n));

   assert_enable_needs_cs_R5: assert property (@(posedge clk) disable iff (rst)
      (!bus_oe_n || !bus_we_n) |-> !bus_cs_n);

   assert_start_without_cs_R3: assert property (@(posedge clk) disable iff (rst)
      !bus_ts_n |-> bus_cs_n);

   assert_ack_strobes_off_R4: assert property (@(posedge clk) disable iff (rst)
      host_ack |-> (bus_cs_n && bus_oe_n && bus_we_n));

   assert_addr_kept_after_ack_R4: assert property (@(posedge clk) disable iff (rst)
      host_ack |=> $stable(bus_addr));

   assert_reset_idle_R11: assert property (@(posedge clk)
      rst |=> (bus_cs_n && bus_oe_n && bus_we_n && bus_ts_n && !host_ack));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .host_ack(host_ack), .bus_addr(bus_addr),
   .bus_cs_n(bus_cs_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_ts_n(bus_ts_n)
);

// File: tb/xbus_ctrl_tb.sv
`timescale 1ns/1ps
module xbus_ctrl_tb;
   localparam int ADDR_W = 16, PORT_W = 8, HOST_W = 32, BEATS = HOST_W / PORT_W;

   logic clk = 1'b0, rst = 1'b1;
   logic host_req = 0, host_we = 0, host_burst = 0;
   logic [ADDR_W-1:0] host_addr = '0;
   logic [PORT_W-1:0] host_wdata = '0;
   logic [1:0] cfg_setup = '0, cfg_hold = '0;
   logic [5:0] cfg_wait = '0;
   logic host_ack, bus_dout_en, bus_cs_n, bus_oe_n, bus_we_n, bus_ts_n;
   logic [HOST_W-1:0] host_rdata;
   logic [ADDR_W-1:0] bus_addr;
   logic [PORT_W-1:0] bus_dout, bus_din;

   always #4 clk = ~clk;

   xbus_ctrl u_dut (.*);

   // external device model: read data derived from the address
   assign bus_din = bus_addr[7:0] ^ 8'hA5;

   typedef struct {
      bit          rd;
      logic [31:0] data;
      int          lat;
      int          hold;
      int          setup;
      logic [15:0] addr;
      bit          gap;
   } item_t;
   item_t q[$];

   int checks = 0, errors = 0, cyc = 0, ts_cyc = 0, ack_cyc = 0, last_hold = 0, hold_left = 0;
   bit cs_seen, saw_oe, saw_we, wen, chained = 0;
   logic [7:0] wbyte;
   logic [15:0] ack_addr;
   item_t cur;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input logic [15:0] a, input bit burst);
      logic [31:0] w = '0;
      for (int k = 0; k < (burst ? BEATS : 1); k++) begin
         logic [15:0] ak = a + 16'(k);
         w[k*8 +: 8] = ak[7:0] ^ 8'hA5;
      end
      return w;
   endfunction

   task automatic xfer(input bit we, input bit burst, input logic [15:0] a, input logic [7:0] wd,
                       input int s, input int w, input int h, input bit scramble);
      item_t it;
      bit bur = burst && !we;
      it.rd    = !we;
      it.data  = we ? {24'd0, wd} : exp_word(a, bur);
      it.lat   = bur ? 3 + s + w + BEATS : 4 + s + w;
      it.hold  = (bur && h == 0) ? 1 : h;
      it.setup = s;
      it.addr  = a;
      it.gap   = chained;
      q.push_back(it);
      host_we = we; host_burst = burst; host_addr = a; host_wdata = wd;
      cfg_setup = 2'(s); cfg_wait = 6'(w); cfg_hold = 2'(h);
      host_req = 1'b1;
      if (scramble) begin
         repeat (2) @(negedge clk);
         host_we = ~we; host_burst = ~burst; host_addr = ~a; host_wdata = ~wd;
         cfg_setup = 2'd0; cfg_wait = 6'd0; cfg_hold = 2'd0;
      end
      do @(negedge clk); while (!host_ack);
      chained = 1;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         cyc++;
         if (hold_left > 0) begin
            chk(bus_cs_n && bus_oe_n && bus_we_n && bus_ts_n && bus_addr == ack_addr,
                "R4 hold clock quiet, address kept", {bus_addr, 12'd0, bus_cs_n, bus_oe_n, bus_we_n, bus_ts_n},
                {ack_addr, 16'h000F});
            hold_left--;
         end
         if (!bus_ts_n) begin
            ts_cyc = cyc; cs_seen = 0; saw_oe = 0; saw_we = 0; wen = 0; wbyte = '0;
            if (q.size() > 0) begin
               cur = q[0];
               chk(bus_addr == cur.addr, "R3/R8 start address", 32'(bus_addr), 32'(cur.addr));
               if (cur.gap)
                  chk(cyc - ack_cyc == last_hold + 2, "R10 next start after hold", cyc - ack_cyc, last_hold + 2);
            end
         end
         if (!bus_cs_n && !cs_seen) begin
            cs_seen = 1;
            chk(cyc - ts_cyc == 1 + cur.setup, "R3 chip select delay", cyc - ts_cyc, 1 + cur.setup);
         end
         if (!bus_oe_n) saw_oe = 1;
         if (!bus_we_n) begin saw_we = 1; wbyte = bus_dout; wen = bus_dout_en; end
         if (host_ack) begin
            if (q.size() == 0) begin
               chk(0, "R9 unexpected acknowledge", 1, 0);
            end else begin
               cur = q.pop_front();
               chk(cyc - ts_cyc + 1 == cur.lat, "R1/R2/R6 acknowledge clock", cyc - ts_cyc + 1, cur.lat);
               if (cur.rd) begin
                  chk(host_rdata == cur.data, "R9/R6 read data", host_rdata, cur.data);
                  chk(saw_oe && !saw_we, "R5 read strobes", {saw_oe, saw_we}, 2'b10);
               end else begin
                  chk(wen && wbyte == cur.data[7:0], "R5/R7 write data", {wen, wbyte}, {1'b1, cur.data[7:0]});
                  chk(saw_we && !saw_oe, "R5 write strobes", {saw_oe, saw_we}, 2'b01);
               end
               ack_cyc = cyc; ack_addr = bus_addr; last_hold = cur.hold; hold_left = cur.hold;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(bus_cs_n && bus_oe_n && bus_we_n && bus_ts_n && !host_ack, "R11 reset state",
          {bus_cs_n, bus_oe_n, bus_we_n, bus_ts_n, host_ack}, 5'b11110);
      rst = 1'b0;
      @(negedge clk);
      xfer(0, 0, 16'h0010, 8'h00, 0, 0, 0, 0);  // R1 basic read
      xfer(1, 0, 16'h0011, 8'h3C, 0, 0, 0, 0);  // R1 R5 basic write
      xfer(0, 0, 16'h0012, 8'h00, 0, 2, 0, 0);  // R2 two wait states
      xfer(1, 0, 16'h0013, 8'hC3, 1, 1, 1, 0);  // R3 R4 setup+wait+hold write
      xfer(0, 1, 16'h0020, 8'h00, 0, 0, 0, 0);  // R6 default burst
      xfer(1, 1, 16'h0030, 8'h5E, 0, 0, 0, 0);  // R7 burst flag on write
      xfer(0, 0, 16'h0040, 8'h00, 3, 63, 3, 1); // R8 fields changed mid-access
      xfer(0, 1, 16'hFFFE, 8'h00, 2, 5, 2, 0);  // R6 burst with setup/wait, wrap
      xfer(1, 0, 16'h0050, 8'hA1, 0, 0, 3, 0);  // R10 long hold then chained read
      xfer(0, 0, 16'h0051, 8'h00, 0, 1, 0, 0);
      host_req = 1'b0;
      repeat (6) @(negedge clk);
      chk(q.size() == 0, "R9 all acknowledges seen", q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule